// File: doc/BRIEF.md
# Shared-Pin GPIO Controller

This block manages eight general-purpose pins for a larger chip. Software sets each pin as an input or an output through a direction register. A data register holds the level each output drives, and it returns the pin levels seen on the inputs. Input levels pass through a two-flop synchronizer before software can read them.

Four of the eight pins also serve three system functions: clock-run, power override and a serial EEPROM. The EEPROM uses two pins, one for clock and one for data. Each function has its own enable input. While a function is enabled it owns its pins. It drives them through its own output and output-enable signals, and the GPIO logic for those pins stays out of the way. Its latches ignore writes and its read view shows zero.

The register port is a plain single-cycle interface. A write is taken on the clock edge where the write strobe is high. A read returns data in the same cycle from the address alone.

Top module: `shared_gpio_ctrl`

## Requirements
- R1: After reset every direction bit is 0, so all eight pins are inputs, `pin_oe` is 0 on every pin that no function owns, and every output latch is 0.
- R2: A write to address 0xB4 sets the direction bits from `reg_wdata[7:0]`. A 1 in bit i makes pin i an output and a 0 makes it an input. The new direction appears on `pin_oe` after the write's clock edge and can be read back at 0xB4.
- R3: Bits 15:8 of the registers at 0xB4 and 0xB6 always read as zero, and writing those bits has no effect.
- R4: A write to address 0xB6 loads the output latch from `reg_wdata[7:0]`. Every pin that no function owns drives its latch bit on `pin_o` after the write's clock edge.
- R5: A read of 0xB6 returns, in bit i, the output latch for each unowned pin whose direction bit is 1.
- R6: A read of 0xB6 returns, in bit i, the synchronized `pin_i[i]` for each unowned input pin. A level change reaches the read data two clock edges after it is applied, and not after one.
- R7: While `clkrun_en` is 1, pin 0 is owned: `pin_o[0]` and `pin_oe[0]` follow `alt_o[0]` and `alt_oe[0]`.
- R8: While `pwrovr_en` is 1, pin 1 is owned: `pin_o[1]` and `pin_oe[1]` follow `alt_o[1]` and `alt_oe[1]`.
- R9: While `eeprom_en` is 1, pins 2 (clock) and 3 (data) are owned and follow `alt_o[3:2]` and `alt_oe[3:2]`.
- R10: Bits of owned pins read as zero at 0xB6.
- R11: A write to 0xB4 or 0xB6 leaves the direction and latch bits of owned pins unchanged. Once the function is disabled, those pins return to their earlier direction and level.
- R12: Reads of any other address return zero, and writes to any other address change neither register.
- R13: Pins 4 to 7 are never owned by a function and stay under GPIO control whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| clkrun_en | input | 1 | Clock-run function owns pin 0 |
| pwrovr_en | input | 1 | Power-override function owns pin 1 |
| eeprom_en | input | 1 | Serial EEPROM function owns pins 2 and 3 |
| alt_o | input | 8 | Output levels from the alternate functions |
| alt_oe | input | 8 | Output enables from the alternate functions |
| pin_i | input | 8 | Pad input levels |
| pin_o | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables |

## Verification
On every cycle the assertions check four things. Writes leave the bits of owned pins alone and update the bits of unowned pins. An unowned pin's output enable changes only when its direction or its ownership changes. The synchronizer output equals the pin level from two edges before. Reads keep the reserved byte at zero and show zero for owned pins. Only the bench scenarios can show the rest. These are the reset values, the exact read values that mix latched outputs with synchronized inputs, the takeover of pins by each function, and the return to the earlier direction and level once a function is disabled.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PIN_CNT = 8;

  // fixed ownership map of the shared pins
  localparam int CLKRUN_PIN = 0;
  localparam int PWROVR_PIN = 1;
  localparam int EE_CLK_PIN = 2;
  localparam int EE_DAT_PIN = 3;

  typedef logic [PIN_CNT-1:0] pin_vec_t;

  // which pins are currently taken by an alternate function
  function automatic pin_vec_t owner_mask(input logic clkrun, input logic pwrovr,
                                          input logic eeprom);
    pin_vec_t m;
    m = '0;
    m[CLKRUN_PIN] = clkrun;
    m[PWROVR_PIN] = pwrovr;
    m[EE_CLK_PIN] = eeprom;
    m[EE_DAT_PIN] = eeprom;
    return m;
  endfunction

  // value software sees at the data register
  function automatic pin_vec_t data_view(input pin_vec_t dir, input pin_vec_t dout,
                                         input pin_vec_t synced, input pin_vec_t owned);
    pin_vec_t v;
    for (int i = 0; i < PIN_CNT; i++) begin
      if (owned[i])    v[i] = 1'b0;
      else if (dir[i]) v[i] = dout[i];
      else             v[i] = synced[i];
    end
    return v;
  endfunction

  // merge new write data only into the bits selected by mask
  function automatic pin_vec_t masked_update(input pin_vec_t cur, input pin_vec_t wdata,
                                             input pin_vec_t mask);
    return (cur & ~mask) | (wdata & mask);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int WARM_W = $clog2(STAGES + 1);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];

  // edges seen since reset, saturating, used to gate the latency check
  logic [WARM_W-1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        warm_q <= '0;
    else if (warm_q != WARM_W'(STAGES)) warm_q <= warm_q + 1'b1;
  end

  if (STAGES == 2) begin : g_lat_chk
    // R6
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == WARM_W'(STAGES)) |-> (dout == $past(din, 2)));
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  DIR_OFS  = 8'hB4,
  parameter logic [7:0]  DATA_OFS = 8'hB6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  pin_vec_t          wdata,
  input  pin_vec_t          owned,
  output pin_vec_t          dir_q,
  output pin_vec_t          dout_q
);
  logic     dir_hit, data_hit;
  pin_vec_t dir_wr_mask, data_wr_mask;

  assign dir_hit      = wr_en && (addr == ADDR_W'(DIR_OFS));
  assign data_hit     = wr_en && (addr == ADDR_W'(DATA_OFS));
  assign dir_wr_mask  = dir_hit  ? ~owned : '0;
  assign data_wr_mask = data_hit ? ~owned : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dout_q <= '0;
    end else begin
      dir_q  <= masked_update(dir_q,  wdata, dir_wr_mask);
      dout_q <= masked_update(dout_q, wdata, data_wr_mask);
    end
  end

  for (genvar i = 0; i < PIN_CNT; i++) begin : g_chk
    // R11
    owned_dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_hit && owned[i]) |=> (dir_q[i] == $past(dir_q[i])));
    // R11
    owned_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_hit && owned[i]) |=> (dout_q[i] == $past(dout_q[i])));
    // R2
    dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_hit && !owned[i]) |=> (dir_q[i] == $past(wdata[i])));
    // R4
    data_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_hit && !owned[i]) |=> (dout_q[i] == $past(wdata[i])));
  end
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
  import gpio_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pin_vec_t owned,
  input  pin_vec_t dir,
  input  pin_vec_t dout,
  input  pin_vec_t alt_o,
  input  pin_vec_t alt_oe,
  output pin_vec_t pin_o,
  output pin_vec_t pin_oe
);
  for (genvar i = 0; i < PIN_CNT; i++) begin : g_pin
    always_comb begin
      if (owned[i]) begin
        pin_o[i]  = alt_o[i];
        pin_oe[i] = alt_oe[i];
      end else begin
        pin_o[i]  = dout[i];
        pin_oe[i] = dir[i];
      end
    end

    // R2
    oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!owned[i] && $stable(owned[i]) && $stable(dir[i])) |-> $stable(pin_oe[i]));
  end
endmodule

// File: rtl/shared_gpio_ctrl.sv
module shared_gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         REG_W       = 16,
  parameter logic [7:0] DIR_OFS     = 8'hB4,
  parameter logic [7:0] DATA_OFS    = 8'hB6,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              clkrun_en,
  input  logic              pwrovr_en,
  input  logic              eeprom_en,
  input  logic [7:0]        alt_o,
  input  logic [7:0]        alt_oe,
  input  logic [7:0]        pin_i,
  output logic [7:0]        pin_o,
  output logic [7:0]        pin_oe
);
  localparam int PAD_W = REG_W - PIN_CNT;

  pin_vec_t owned, dir_q, dout_q, synced, rd_view;
  logic     rd_dir, rd_data;

  assign owned = owner_mask(clkrun_en, pwrovr_en, eeprom_en);

  gpio_sync #(.W(PIN_CNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_i), .dout(synced)
  );

  gpio_regs #(.ADDR_W(ADDR_W), .DIR_OFS(DIR_OFS), .DATA_OFS(DATA_OFS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata[PIN_CNT-1:0]), .owned(owned), .dir_q(dir_q), .dout_q(dout_q)
  );

  gpio_pinmux u_mux (
    .clk(clk), .rst_n(rst_n), .owned(owned), .dir(dir_q), .dout(dout_q),
    .alt_o(alt_o), .alt_oe(alt_oe), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  assign rd_dir  = (reg_addr == ADDR_W'(DIR_OFS));
  assign rd_data = (reg_addr == ADDR_W'(DATA_OFS));
  assign rd_view = data_view(dir_q, dout_q, synced, owned);

  always_comb begin
    if (rd_dir)       reg_rdata = {{PAD_W{1'b0}}, dir_q};
    else if (rd_data) reg_rdata = {{PAD_W{1'b0}}, rd_view};
    else              reg_rdata = '0;
  end

  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dir || rd_data) |-> (reg_rdata[REG_W-1:PIN_CNT] == '0));
  // R10
  owned_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data |-> ((reg_rdata[PIN_CNT-1:0] & owned) == '0));
  // R12
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_dir && !rd_data) |-> (reg_rdata == '0));
endmodule

// File: tb/shared_gpio_ctrl_tb.sv
module shared_gpio_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        clkrun_en = 1'b0, pwrovr_en = 1'b0, eeprom_en = 1'b0;
  logic [7:0]  alt_o = 8'h00, alt_oe = 8'h00, pin_i = 8'h00;
  logic [7:0]  pin_o, pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  shared_gpio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clkrun_en(clkrun_en),
    .pwrovr_en(pwrovr_en), .eeprom_en(eeprom_en), .alt_o(alt_o), .alt_oe(alt_oe),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(8'hB4, d); check("R1 dir after reset", d, 16'h0000);
    check("R1 pin_oe after reset", {8'h0, pin_oe}, 16'h0000);
    check("R1 pin_o after reset", {8'h0, pin_o}, 16'h0000);
    rd(8'hB6, d); check("R1 data after reset", d, 16'h0000);
  endtask

  task automatic t_direction();
    logic [15:0] d;
    wr(8'hB4, 16'hABF0);
    rd(8'hB4, d); check("R2 R3 dir readback", d, 16'h00F0);
    check("R2 pin_oe follows dir", {8'h0, pin_oe}, 16'h00F0);
  endtask

  task automatic t_data_out();
    logic [15:0] d;
    pin_i = 8'h03;
    wr(8'hB6, 16'hFF5A);
    @(negedge clk); @(negedge clk);
    check("R4 pin_o drives latch", {8'h0, pin_o}, 16'h005A);
    rd(8'hB6, d); check("R3 R5 R6 mixed data read", d, 16'h0053);
  endtask

  task automatic t_sync();
    logic [15:0] d;
    @(negedge clk); pin_i = 8'h0C;
    @(negedge clk);
    rd(8'hB6, d); check("R6 one edge still old", d, 16'h0053);
    @(negedge clk);
    rd(8'hB6, d); check("R6 two edges new level", d, 16'h005C);
  endtask

  task automatic t_alt();
    logic [15:0] d;
    alt_o = 8'hFF; alt_oe = 8'hFF;
    @(negedge clk); clkrun_en = 1'b1; #1;
    check("R7 clkrun oe", {8'h0, pin_oe}, 16'h00F1);
    check("R7 clkrun out", {8'h0, pin_o}, 16'h005B);
    rd(8'hB6, d); check("R10 clkrun pin reads zero", d, 16'h005C);
    @(negedge clk); pwrovr_en = 1'b1; #1;
    check("R8 pwrovr oe", {8'h0, pin_oe}, 16'h00F3);
    alt_o = 8'hFD; #1;
    check("R8 pwrovr out follows alt", {8'h0, pin_o}, 16'h0059);
    alt_o = 8'hFF;
    @(negedge clk); eeprom_en = 1'b1; #1;
    check("R9 eeprom oe", {8'h0, pin_oe}, 16'h00FF);
    check("R9 eeprom out", {8'h0, pin_o}, 16'h005F);
    rd(8'hB6, d); check("R10 R13 owned zero, upper pins GPIO", d, 16'h0050);
  endtask

  task automatic t_ignore();
    logic [15:0] d;
    wr(8'hB4, 16'h000F);
    wr(8'hB6, 16'h000F);
    check("R13 pins 4-7 take dir write", {8'h0, pin_oe}, 16'h000F);
    @(negedge clk);
    clkrun_en = 1'b0; pwrovr_en = 1'b0; eeprom_en = 1'b0;
    #1;
    rd(8'hB4, d); check("R11 owned dir bits kept", d, 16'h0000);
    check("R11 owned latch bits kept", {8'h0, pin_o}, 16'h000A);
    check("R11 pin_oe after release", {8'h0, pin_oe}, 16'h0000);
    rd(8'hB6, d); check("R6 all inputs read sync", d, 16'h000C);
  endtask

  task automatic t_other_addr();
    logic [15:0] d;
    wr(8'hB5, 16'hFFFF);
    wr(8'h00, 16'hFFFF);
    check("R12 write elsewhere no oe change", {8'h0, pin_oe}, 16'h0000);
    check("R12 write elsewhere no out change", {8'h0, pin_o}, 16'h000A);
    rd(8'hB5, d); check("R12 read 0xB5", d, 16'h0000);
    rd(8'h00, d); check("R12 read 0x00", d, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direction();
    t_data_out();
    t_sync();
    t_alt();
    t_ignore();
    t_other_addr();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule